// File: doc/BRIEF.md
# Edge and Level Interrupt Steering Controller

This block gathers 32 interrupt inputs and turns them into two request lines and one wake line. Each input is synchronised and then judged under its own trigger mode. The mode is a three-bit code, and each bit of that code lives in its own configuration plane. Edge-mode inputs latch their events until software clears them. Level-mode inputs request only while the pin holds its active level. Each input then passes a mask plane and a routing plane. The routing plane steers it either to the high-priority request line or to the normal request line.

Every per-source plane is written through a pair of word addresses. Writing to the set address turns on the bits that are 1 in the written word. Writing to the clear address turns them off. Bits written as 0 are left as they were, so software never needs a read-modify-write. Two further registers are provided:
- a readable pending word for each request line;
- a system wake mask that limits wakeup to the lowest eight inputs.

A select plane normally feeds each source from its pin. A test word can stand in for the pin of any source whose select bit is cleared.

Top module: `irq_steer_ctrl`

## Requirements
- R1: After reset, every plane reads 0 except the select plane, which reads all ones. The edge latches, the pending words, irqHi, irqLo and wakeOut are all 0.
- R2: The planes sit at word addresses 2p (set) and 2p+1 (clear), both of which read the plane. The planes are p=0 code bit0, p=1 code bit1, p=2 code bit2, p=3 mask, p=4 route, p=5 wake enable and p=6 select. A write changes only the bit positions written as 1.
- R3: Code 001 ({bit2,bit1,bit0}) latches a rising edge of the source into the rising-latch word (address 14) and does not react to falling edges.
- R4: Code 010 latches falling edges into the falling-latch word (address 15) and does not react to rising edges.
- R5: Code 011 latches both edges, each into its own latch word. An edge-mode source is active while either of its latch bits is set.
- R6: Code 101 makes the source active exactly while its input is 1, and it sets no latch.
- R7: Code 110 makes the source active exactly while its input is 0, and it sets no latch.
- R8: Codes 000, 100 and 111 never set a latch and never make the source active.
- R9: Writing a word to address 14 clears the rising latches at its 1 positions, and writing to address 15 does the same for the falling latches. All other latch bits are kept.
- R10: The pending-high word (address 18) is active & mask & route, and the pending-low word (address 19) is active & mask & ~route. A masked source still latches its edges.
- R11: irqHi is 1 exactly when the pending-high word is non-zero, and irqLo is 1 exactly when the pending-low word is non-zero.
- R12: wakeOut is the OR over sources of active & wake-enable & system-wake-bit. The system wake register (address 17) keeps only bits 7..0, so sources 8 and above never wake. The mask does not gate wakeOut.
- R13: A source whose select bit is 0 takes bit i of the test word (address 16) as its input instead of its pin. When the select bit is 1, the test word has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcIn | input | 32 | Raw interrupt inputs, one bit per source |
| busAddr | input | 5 | Word address for the register bus |
| busWr | input | 1 | Write strobe, one word per cycle |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr, combinational |
| irqHi | output | 1 | High-priority request line |
| irqLo | output | 1 | Normal-priority request line |
| wakeOut | output | 1 | Wake request |

## Verification
The following properties are checked on every cycle:
- set and clear writes touch only the addressed bits;
- an edge latch never gains a bit whose code does not select that edge;
- a latch-clear write leaves no written bit set unless a new edge arrives in the same cycle;
- the reset state holds when reset is released.

Some behaviour can only be shown by the bench scenarios. These are the sweep of every code over a rising-then-falling pulse on each of the 32 sources, with either routing, together with the pending word and line values that result. The scenarios also cover the mask hiding requests while latching continues, wakeup while the source is masked, the eight-source wake limit, and the test-word substitution.

// File: rtl/irqsc_pkg.sv
package irqsc_pkg;
  localparam int NPLANE = 7;
  localparam int PL_CFG0  = 0;
  localparam int PL_CFG1  = 1;
  localparam int PL_CFG2  = 2;
  localparam int PL_MASK  = 3;
  localparam int PL_ROUTE = 4;
  localparam int PL_WAKE  = 5;
  localparam int PL_SEL   = 6;

  localparam int ADR_RISE    = 2 * NPLANE;
  localparam int ADR_FALL    = ADR_RISE + 1;
  localparam int ADR_TEST    = ADR_RISE + 2;
  localparam int ADR_SYSWAKE = ADR_RISE + 3;
  localparam int ADR_PENDHI  = ADR_RISE + 4;
  localparam int ADR_PENDLO  = ADR_RISE + 5;

  typedef struct packed {
    logic [NPLANE-1:0] planeSet;
    logic [NPLANE-1:0] planeClr;
    logic              riseClr;
    logic              fallClr;
    logic              testWr;
    logic              sysWakeWr;
  } strobe_t;
endpackage

// File: rtl/irqsc_decode.sv
module irqsc_decode
  import irqsc_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  output strobe_t           strb
);
  localparam logic [ADDR_W-1:0] PlaneEnd = ADDR_W'(2 * NPLANE);

  always_comb begin
    strb = '0;
    if (busWr) begin
      if (busAddr < PlaneEnd) begin
        for (int p = 0; p < NPLANE; p++) begin
          if ((busAddr >> 1) == ADDR_W'(p)) begin
            if (busAddr[0]) strb.planeClr[p] = 1'b1;
            else            strb.planeSet[p] = 1'b1;
          end
        end
      end else if (busAddr == ADDR_W'(ADR_RISE))    strb.riseClr   = 1'b1;
      else if (busAddr == ADDR_W'(ADR_FALL))        strb.fallClr   = 1'b1;
      else if (busAddr == ADDR_W'(ADR_TEST))        strb.testWr    = 1'b1;
      else if (busAddr == ADDR_W'(ADR_SYSWAKE))     strb.sysWakeWr = 1'b1;
    end
  end
endmodule

// File: rtl/irqsc_core.sv
module irqsc_core
  import irqsc_pkg::*;
#(
  parameter int NSRC        = 32,
  parameter int WAKE_SRCS   = 8,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NSRC-1:0]   srcIn,
  input  strobe_t           strb,
  input  logic [NSRC-1:0]   wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [NSRC-1:0]   rdData,
  output logic [NSRC-1:0]   pendHi,
  output logic [NSRC-1:0]   pendLo,
  output logic              wakeAny
);
  localparam logic [ADDR_W-1:0] PlaneEnd = ADDR_W'(2 * NPLANE);

  logic [NSRC-1:0] planeQ [NPLANE];
  logic [NSRC-1:0] riseQ, fallQ, testQ, prevQ;
  logic [WAKE_SRCS-1:0] sysWakeQ;
  logic [SYNC_STAGES-1:0][NSRC-1:0] syncQ;
  logic [NSRC-1:0] pinSync, effIn, riseMode, fallMode, lvlHi, lvlLo;
  logic [NSRC-1:0] riseEv, fallEv, active;

  // configuration, mask, route, wake and select planes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int p = 0; p < NPLANE; p++) planeQ[p] <= (p == PL_SEL) ? '1 : '0;
    end else begin
      for (int p = 0; p < NPLANE; p++) begin
        if (strb.planeSet[p])      planeQ[p] <= planeQ[p] | wrData;
        else if (strb.planeClr[p]) planeQ[p] <= planeQ[p] & ~wrData;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ    <= '0;
      prevQ    <= '0;
      riseQ    <= '0;
      fallQ    <= '0;
      testQ    <= '0;
      sysWakeQ <= '0;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], srcIn};
      prevQ <= effIn;
      riseQ <= (riseQ & ~(strb.riseClr ? wrData : '0)) | riseEv;
      fallQ <= (fallQ & ~(strb.fallClr ? wrData : '0)) | fallEv;
      if (strb.testWr)    testQ    <= wrData;
      if (strb.sysWakeWr) sysWakeQ <= wrData[WAKE_SRCS-1:0];
    end
  end

  assign pinSync = syncQ[SYNC_STAGES-1];
  assign effIn   = (planeQ[PL_SEL] & pinSync) | (~planeQ[PL_SEL] & testQ);

  // per-source trigger decode
  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic [2:0] code;
    assign code        = {planeQ[PL_CFG2][i], planeQ[PL_CFG1][i], planeQ[PL_CFG0][i]};
    assign riseMode[i] = (code == 3'b001) || (code == 3'b011);
    assign fallMode[i] = (code == 3'b010) || (code == 3'b011);
    assign lvlHi[i]    = (code == 3'b101);
    assign lvlLo[i]    = (code == 3'b110);
    assign active[i]   = ((riseMode[i] | fallMode[i]) & (riseQ[i] | fallQ[i]))
                       | (lvlHi[i] & effIn[i]) | (lvlLo[i] & ~effIn[i]);
  end

  assign riseEv  = effIn & ~prevQ & riseMode;
  assign fallEv  = ~effIn & prevQ & fallMode;
  assign pendHi  = active & planeQ[PL_MASK] & planeQ[PL_ROUTE];
  assign pendLo  = active & planeQ[PL_MASK] & ~planeQ[PL_ROUTE];
  assign wakeAny = |(active & planeQ[PL_WAKE] & NSRC'(sysWakeQ));

  always_comb begin
    rdData = '0;
    if (rdAddr < PlaneEnd) begin
      for (int p = 0; p < NPLANE; p++)
        if ((rdAddr >> 1) == ADDR_W'(p)) rdData = planeQ[p];
    end else if (rdAddr == ADDR_W'(ADR_RISE))    rdData = riseQ;
    else if (rdAddr == ADDR_W'(ADR_FALL))        rdData = fallQ;
    else if (rdAddr == ADDR_W'(ADR_TEST))        rdData = testQ;
    else if (rdAddr == ADDR_W'(ADR_SYSWAKE))     rdData = NSRC'(sysWakeQ);
    else if (rdAddr == ADDR_W'(ADR_PENDHI))      rdData = pendHi;
    else if (rdAddr == ADDR_W'(ADR_PENDLO))      rdData = pendLo;
  end

  // R1: reset state seen on release
  p_reset_state_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (planeQ[PL_SEL] == '1 && planeQ[PL_MASK] == '0 && riseQ == '0 && fallQ == '0));

  // R2: set write touches only written ones
  p_w1s_mask_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.planeSet[PL_MASK] |=> (((planeQ[PL_MASK] & $past(wrData)) == $past(wrData)) &&
      ((planeQ[PL_MASK] & ~$past(wrData)) == ($past(planeQ[PL_MASK]) & ~$past(wrData)))));

  // R2: clear write touches only written ones
  p_w1c_mask_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.planeClr[PL_MASK] |=> (((planeQ[PL_MASK] & $past(wrData)) == '0) &&
      ((planeQ[PL_MASK] & ~$past(wrData)) == ($past(planeQ[PL_MASK]) & ~$past(wrData)))));

  // R8: a latch bit only appears where the code selects that edge
  p_rise_needs_mode_r8: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((riseQ & ~$past(riseQ) & ~($past(planeQ[PL_CFG0]) & ~$past(planeQ[PL_CFG2]))) == '0));
  p_fall_needs_mode_r8: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((fallQ & ~$past(fallQ) & ~($past(planeQ[PL_CFG1]) & ~$past(planeQ[PL_CFG2]))) == '0));

  // R9: clear write removes written latch bits unless a fresh edge arrived
  p_rise_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.riseClr |=> ((riseQ & $past(wrData) & ~$past(riseEv)) == '0));
endmodule

// File: rtl/irq_steer_ctrl.sv
module irq_steer_ctrl
  import irqsc_pkg::*;
#(
  parameter int NSRC        = 32,
  parameter int WAKE_SRCS   = 8,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NSRC-1:0]   srcIn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic [NSRC-1:0]   busWrData,
  output logic [NSRC-1:0]   busRdData,
  output logic              irqHi,
  output logic              irqLo,
  output logic              wakeOut
);
  strobe_t strb;
  logic [NSRC-1:0] pendHi, pendLo;

  irqsc_decode #(.ADDR_W(ADDR_W)) u_decode (
    .busAddr(busAddr), .busWr(busWr), .strb(strb)
  );

  irqsc_core #(
    .NSRC(NSRC), .WAKE_SRCS(WAKE_SRCS), .SYNC_STAGES(SYNC_STAGES), .ADDR_W(ADDR_W)
  ) u_core (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .strb(strb), .wrData(busWrData),
    .rdAddr(busAddr), .rdData(busRdData), .pendHi(pendHi), .pendLo(pendLo),
    .wakeAny(wakeOut)
  );

  assign irqHi = |pendHi;
  assign irqLo = |pendLo;
endmodule

// File: tb/irq_steer_ctrl_tb.sv
`timescale 1ns/1ps
module irq_steer_ctrl_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [31:0] pins = '0;
  logic [4:0]  addr = '0;
  logic        wrEn = 1'b0;
  logic [31:0] wdat = '0;
  logic [31:0] rdat;
  logic irqHi, irqLo, wakeOut;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  irq_steer_ctrl u_dut (
    .clk(clk), .rstN(rstN), .srcIn(pins), .busAddr(addr), .busWr(wrEn),
    .busWrData(wdat), .busRdData(rdat), .irqHi(irqHi), .irqLo(irqLo), .wakeOut(wakeOut)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    addr = 5'(a); wdat = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; wdat = '0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    addr = 5'(a);
    #1 d = rdat;
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic string codeTag(input int c);
    case (c)
      1: return "R3";
      2: return "R4";
      3: return "R5";
      5: return "R6";
      6: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic checkSrc(input int i, input int c, input bit route, input bit riseE,
                          input bit fallE, input bit actE, input string ph);
    logic [31:0] v, bitv;
    string t;
    t = codeTag(c);
    bitv = 32'h1 << i;
    rd(14, v); chk(t, {ph, " rise latch"}, v, riseE ? bitv : '0);
    rd(15, v); chk(t, {ph, " fall latch"}, v, fallE ? bitv : '0);
    rd(18, v); chk("R10", {ph, " pend hi"}, v, (actE && route) ? bitv : '0);
    rd(19, v); chk("R10", {ph, " pend lo"}, v, (actE && !route) ? bitv : '0);
    chk("R11", {ph, " irqHi"}, {31'b0, irqHi}, {31'b0, actE && route});
    chk("R11", {ph, " irqLo"}, {31'b0, irqLo}, {31'b0, actE && !route});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tick(1);

    // R1 reset state
    for (int a = 0; a < 14; a += 2) begin
      rd(a, v); chk("R1", $sformatf("plane addr %0d", a), v, (a == 12) ? 32'hFFFF_FFFF : 32'h0);
    end
    rd(14, v); chk("R1", "rise latch", v, 0);
    rd(15, v); chk("R1", "fall latch", v, 0);
    rd(18, v); chk("R1", "pend hi", v, 0);
    rd(19, v); chk("R1", "pend lo", v, 0);
    chk("R1", "outputs", {29'b0, irqHi, irqLo, wakeOut}, 0);

    // R2 set/clear semantics on mask plane
    wr(6, 32'h0000_F0F0); rd(6, v); chk("R2", "mask set", v, 32'h0000_F0F0);
    wr(6, 32'h0000_0003); rd(6, v); chk("R2", "mask set more", v, 32'h0000_F0F3);
    wr(7, 32'h0000_00F0); rd(7, v); chk("R2", "mask clear", v, 32'h0000_F003);
    wr(7, 32'h0000_0000); rd(6, v); chk("R2", "zero clear", v, 32'h0000_F003);
    wr(13, 32'h8000_0001); rd(12, v); chk("R2", "sel clear", v, 32'h7FFF_FFFE);
    wr(12, 32'h8000_0001); rd(12, v); chk("R2", "sel set", v, 32'hFFFF_FFFF);
    wr(7, 32'hFFFF_FFFF);

    // R3..R8, R10, R11: sweep every source, codes cycle through all eight
    for (int i = 0; i < 32; i++) begin
      int c;
      bit route, rE, fE;
      c = i % 8;
      route = i[3];
      if (c[0]) wr(0, 32'h1 << i);
      if (c[1]) wr(2, 32'h1 << i);
      if (c[2]) wr(4, 32'h1 << i);
      wr(6, 32'h1 << i);
      wr(route ? 8 : 9, 32'h1 << i);
      wr(14, 32'h1 << i);
      wr(15, 32'h1 << i);
      tick(2);
      checkSrc(i, c, route, 1'b0, 1'b0, c == 6, "idle");
      pins[i] = 1'b1; tick(4);
      rE = (c == 1) || (c == 3);
      checkSrc(i, c, route, rE, 1'b0, rE || (c == 5), "high");
      pins[i] = 1'b0; tick(4);
      fE = (c == 2) || (c == 3);
      checkSrc(i, c, route, rE, fE, rE || fE || (c == 6), "low");
      wr(1, 32'h1 << i); wr(3, 32'h1 << i); wr(5, 32'h1 << i);
      wr(14, 32'h1 << i); wr(15, 32'h1 << i); wr(7, 32'h1 << i);
    end

    // R9 latch clear
    wr(0, 32'h10); wr(6, 32'h10); wr(8, 32'h10);
    pins[4] = 1'b1; tick(4);
    wr(14, 32'h0); rd(14, v); chk("R9", "zero write keeps", v, 32'h10);
    wr(15, 32'h10); rd(14, v); chk("R9", "fall clear keeps rise", v, 32'h10);
    wr(14, 32'h10); rd(14, v); chk("R9", "rise cleared", v, 32'h0);
    chk("R11", "irqHi after clear", {31'b0, irqHi}, 0);
    pins[4] = 1'b0; wr(1, 32'h10); tick(3);

    // R10 masked source still latches; R12 wake while masked
    wr(0, 32'h80); wr(8, 32'h80);
    pins[7] = 1'b1; tick(4);
    rd(14, v); chk("R10", "masked latch", v, 32'h80);
    rd(18, v); chk("R10", "masked pend", v, 0);
    wr(6, 32'h80); rd(18, v); chk("R10", "unmasked pend", v, 32'h80);
    chk("R11", "irqHi unmasked", {31'b0, irqHi}, 1);
    wr(7, 32'h80);
    wr(10, 32'h80); wr(17, 32'hFFFF_FFFF);
    rd(17, v); chk("R12", "syswake width", v, 32'hFF);
    chk("R12", "wake while masked", {31'b0, wakeOut}, 1);
    chk("R11", "irqHi masked", {31'b0, irqHi}, 0);
    wr(17, 32'h7F); chk("R12", "syswake bit off", {31'b0, wakeOut}, 0);
    wr(17, 32'hFF); wr(11, 32'h80); chk("R12", "wake enable off", {31'b0, wakeOut}, 0);
    wr(14, 32'h80); pins[7] = 1'b0; wr(1, 32'h80);
    wr(0, 32'h200); wr(4, 32'h200); wr(10, 32'h200);
    pins[9] = 1'b1; tick(4);
    chk("R12", "source 9 cannot wake", {31'b0, wakeOut}, 0);
    pins[9] = 1'b0; wr(1, 32'h200); wr(5, 32'h200); tick(3);

    // R13 test word substitution
    wr(0, 32'h20); wr(4, 32'h20); wr(6, 32'h20); wr(9, 32'h20);
    wr(13, 32'h20); wr(16, 32'h20); tick(1);
    rd(19, v); chk("R13", "test drives source", v, 32'h20);
    wr(16, 32'h0); tick(1);
    rd(19, v); chk("R13", "test low", v, 0);
    pins[5] = 1'b1; tick(4);
    rd(19, v); chk("R13", "pin ignored when deselected", v, 0);
    wr(12, 32'h20); tick(1);
    rd(19, v); chk("R13", "pin restored", v, 32'h20);
    pins[5] = 1'b0; wr(16, 32'h20); tick(4);
    rd(19, v); chk("R13", "test no effect when selected", v, 0);
    chk("R11", "irqLo idle", {31'b0, irqLo}, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule